// File: doc/BRIEF.md
# Context Completion Event Register

This block collects completion interrupts from four receive contexts into one register that software can read and clear. Each context drives a completion line. A low-to-high transition on that line latches a sticky event bit for the context. Software can also force event bits on. Event bits leave the set state only through an explicit write-one-to-clear access.

A small mask register sits beside the event bits. Two read views are provided: one returns the raw events, and the other returns only the events that the mask enables. A single summary output is the OR of the enabled events. A parent interrupt controller uses this output as one of its own event sources.

Software reaches the block through a plain register-bus slave. The slave has an address, a write enable, write data and combinational read data. Every access completes in one cycle.

Top module: `irq_event_regs`

## Requirements
- R1: After reset, all event bits and all mask bits are 0, `irq_out` is 0, and reads at the set-view address (0xA0), the clear-view address (0xA4) and the mask address (0xA8) all return 0.
- R2: At every address, read-data bits 31..4 are always 0.
- R3: When `irq_in[i]` is sampled 1 and was sampled 0 on the previous clock, event bit i is 1 after that clock edge. A level held high does not set the bit again once it has been cleared.
- R4: A write to 0xA0 sets event bit i for every `wdata[i]` (i in 0..3) that is 1. A write of 0 leaves that bit unchanged.
- R5: A write to 0xA4 clears event bit i for every `wdata[i]` that is 1. A write of 0 leaves that bit unchanged. Nothing else clears an event bit, including a falling `irq_in`.
- R6: When a set (an input edge or a write to 0xA0) and a clear of the same bit fall in the same cycle, the bit ends up 1.
- R7: A read at 0xA0 returns the raw event bits in `rdata[3:0]`, with bit i belonging to context i.
- R8: A read at 0xA4 returns the event bits ANDed bitwise with the mask in `rdata[3:0]`.
- R9: The mask is a read/write register at 0xA8 held in `wdata[3:0]`/`rdata[3:0]`. Writing it changes no event bit.
- R10: `irq_out` is 1 exactly when some event bit and its mask bit are both 1. It follows register updates in the same cycle.
- R11: A write to any other address changes no state, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 4 | Completion lines, one per context |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq_out | output | 1 | Summary of enabled events |

## Verification
The bench holds a completion line high across a clear. A level-sensitive design would latch the event again, and the read after the clear would show it still set. It lowers a line while its event is pending, which exposes any design that lets the input falling edge clear the bit. It raises a line in the same cycle that software clears that bit, so a clear-priority design loses the event. It also writes zeros to both the set and clear addresses and writes to an unmapped address; a sloppy decoder would disturb the events or the mask there. Clear-view reads under partial masks and `irq_out` under an all-zero mask expose any design that reports events the mask has disabled.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

    // Kind of register access decoded from the bus in one cycle
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_MASK = 2'd3
    } evt_acc_e;

    // Default byte offsets of the three views
    localparam logic [7:0] DEF_SET_OFS  = 8'hA0;
    localparam logic [7:0] DEF_CLR_OFS  = 8'hA4;
    localparam logic [7:0] DEF_MASK_OFS = 8'hA8;

endpackage

// File: rtl/ctx_edge_detect.sv
module ctx_edge_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // One pulse for every low-to-high transition between consecutive samples
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_rise
            assign rise_o[g] = lvl_i[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/evt_bus_decode.sv
module evt_bus_decode
    import irq_evt_pkg::*;
#(
    parameter int              N        = 4,
    parameter int              AW       = 8,
    parameter int              DW       = 32,
    parameter logic [AW-1:0]   SET_OFS  = AW'(DEF_SET_OFS),
    parameter logic [AW-1:0]   CLR_OFS  = AW'(DEF_CLR_OFS),
    parameter logic [AW-1:0]   MASK_OFS = AW'(DEF_MASK_OFS)
) (
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [N-1:0]  evt_i,
    input  logic [N-1:0]  mask_i,
    output logic [N-1:0]  set_wr_o,
    output logic [N-1:0]  clr_wr_o,
    output logic          mask_we_o,
    output logic [N-1:0]  mask_wdata_o,
    output logic [DW-1:0] rdata_o
);

    evt_acc_e acc;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DW-1:N];

    always_comb begin
        if      (addr_i == SET_OFS)  acc = ACC_SET;
        else if (addr_i == CLR_OFS)  acc = ACC_CLR;
        else if (addr_i == MASK_OFS) acc = ACC_MASK;
        else                         acc = ACC_NONE;
    end

    always_comb begin
        set_wr_o     = '0;
        clr_wr_o     = '0;
        mask_we_o    = 1'b0;
        mask_wdata_o = wdata_i[N-1:0];
        if (wr_en_i) begin
            unique case (acc)
                ACC_SET:  set_wr_o  = wdata_i[N-1:0];
                ACC_CLR:  clr_wr_o  = wdata_i[N-1:0];
                ACC_MASK: mask_we_o = 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (acc)
            ACC_SET:  rdata_o[N-1:0] = evt_i;
            ACC_CLR:  rdata_o[N-1:0] = evt_i & mask_i;
            ACC_MASK: rdata_o[N-1:0] = mask_i;
            default:  ;
        endcase
    end

endmodule

// File: rtl/evt_state.sv
module evt_state #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] set_wr_i,
    input  logic [N-1:0] clr_wr_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_wdata_i,
    output logic [N-1:0] evt_o,
    output logic [N-1:0] mask_o
);

    typedef struct packed {
        logic [N-1:0] evt;
        logic [N-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Clear first, then OR in every set source: a set in the same cycle wins
        st_d.evt = (st_q.evt & ~clr_wr_i) | rise_i | set_wr_i;
        if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o  = st_q.evt;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
    import irq_evt_pkg::*;
#(
    parameter int            NUM_CTX  = 4,
    parameter int            ADDR_W   = 8,
    parameter int            DATA_W   = 32,
    parameter logic [ADDR_W-1:0] SET_OFS  = ADDR_W'(DEF_SET_OFS),
    parameter logic [ADDR_W-1:0] CLR_OFS  = ADDR_W'(DEF_CLR_OFS),
    parameter logic [ADDR_W-1:0] MASK_OFS = ADDR_W'(DEF_MASK_OFS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] irq_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_out
);

    logic [NUM_CTX-1:0] rise_w;
    logic [NUM_CTX-1:0] set_wr_w;
    logic [NUM_CTX-1:0] clr_wr_w;
    logic               mask_we_w;
    logic [NUM_CTX-1:0] mask_wdata_w;
    logic [NUM_CTX-1:0] evt_w;
    logic [NUM_CTX-1:0] mask_w;

    ctx_edge_detect #(.N(NUM_CTX)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (irq_in),
        .rise_o (rise_w)
    );

    evt_bus_decode #(
        .N        (NUM_CTX),
        .AW       (ADDR_W),
        .DW       (DATA_W),
        .SET_OFS  (SET_OFS),
        .CLR_OFS  (CLR_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_dec (
        .addr_i       (addr),
        .wr_en_i      (wr_en),
        .wdata_i      (wdata),
        .evt_i        (evt_w),
        .mask_i       (mask_w),
        .set_wr_o     (set_wr_w),
        .clr_wr_o     (clr_wr_w),
        .mask_we_o    (mask_we_w),
        .mask_wdata_o (mask_wdata_w),
        .rdata_o      (rdata)
    );

    evt_state #(.N(NUM_CTX)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_i       (rise_w),
        .set_wr_i     (set_wr_w),
        .clr_wr_i     (clr_wr_w),
        .mask_we_i    (mask_we_w),
        .mask_wdata_i (mask_wdata_w),
        .evt_o        (evt_w),
        .mask_o       (mask_w)
    );

    assign irq_out = |(evt_w & mask_w);

endmodule

// File: rtl/irq_event_regs_chk.sv
module irq_event_regs_chk #(
    parameter int            N      = 4,
    parameter int            AW     = 8,
    parameter int            DW     = 32,
    parameter logic [AW-1:0] CLR_OFS = 8'hA4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata,
    input logic          irq_out,
    input logic [N-1:0]  rise,
    input logic [N-1:0]  set_wr,
    input logic [N-1:0]  clr_wr,
    input logic [N-1:0]  evt,
    input logic [N-1:0]  mask
);

    // R3: a detected edge leaves its event bit set after the clock
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((evt & $past(rise)) == $past(rise)));

    // R6: any set source beats a clear of the same bit
    a_r6_set_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_wr | rise) != '0) |=> ((evt & $past(set_wr | rise)) == $past(set_wr | rise)));

    // R5: a bit only falls where a write-one-to-clear hit it
    a_r5_clear_only_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(evt) & ~evt) & ~$past(clr_wr)) == '0));

    // R2: upper read bits stay zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[DW-1:N] == '0));

    // R8: the clear view never shows a masked-off bit
    a_r8_clear_view_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CLR_OFS) |-> ((rdata[N-1:0] & ~mask) == '0));

    // R10: with every context disabled the summary is quiet
    a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_out);

endmodule

bind irq_event_regs irq_event_regs_chk #(
    .N       (NUM_CTX),
    .AW      (ADDR_W),
    .DW      (DATA_W),
    .CLR_OFS (CLR_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rdata   (rdata),
    .irq_out (irq_out),
    .rise    (rise_w),
    .set_wr  (set_wr_w),
    .clr_wr  (clr_wr_w),
    .evt     (evt_w),
    .mask    (mask_w)
);

// File: tb/tb_irq_event_regs.sv
module tb_irq_event_regs;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_SET  = 8'hA0;
    localparam logic [7:0] A_CLR  = 8'hA4;
    localparam logic [7:0] A_MASK = 8'hA8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_in = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    irq_event_regs dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] exp_rd;
        logic        exp_irq;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model of the requirements
    logic [3:0] m_evt = '0, m_mask = '0, m_prev = '0;

    // Drive one cycle; optionally queue the read expected during it
    task automatic step(input logic [3:0] irq, input logic wr, input logic [7:0] a,
                        input logic [31:0] d, input bit chk, input string tag);
        logic [3:0] setv, clrv;
        item_t it;
        @(posedge clk); #1;
        irq_in = irq; wr_en = wr; addr = a; wdata = d;
        if (chk) begin
            it.exp_rd = '0;
            if (a == A_SET)       it.exp_rd[3:0] = m_evt;
            else if (a == A_CLR)  it.exp_rd[3:0] = m_evt & m_mask;
            else if (a == A_MASK) it.exp_rd[3:0] = m_mask;
            it.exp_irq = |(m_evt & m_mask);
            it.tag = tag;
            sb.push_back(it);
        end
        setv = (irq & ~m_prev) | ((wr && a == A_SET) ? d[3:0] : 4'h0);
        clrv = (wr && a == A_CLR) ? d[3:0] : 4'h0;
        m_evt = (m_evt & ~clrv) | setv;
        if (wr && a == A_MASK) m_mask = d[3:0];
        m_prev = irq;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(irq_in, 1'b0, a, 32'h0, 1'b1, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(irq_in, 1'b1, a, d, 1'b0, "");
    endtask

    // Monitor: compare each queued expectation away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (rdata !== it.exp_rd || irq_out !== it.exp_irq) begin
                n_bad++;
                $display("FAIL %s: rdata=%h irq_out=%b expected rdata=%h irq_out=%b",
                         it.tag, rdata, irq_out, it.exp_rd, it.exp_irq);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        rd(A_SET, "R1 set view after reset");
        rd(A_CLR, "R1 clear view after reset");
        rd(A_MASK, "R1 mask after reset");
        // R9 mask write, upper data ignored; R2 reserved bits
        wr(A_MASK, 32'hFFFF_FFF5);
        rd(A_MASK, "R9 mask readback / R2 reserved bits");
        rd(A_SET, "R9 mask write leaves events");
        // R3 edge on context 1
        step(4'b0010, 1'b0, A_SET, 32'h0, 1'b0, "");
        rd(A_SET, "R3 rising edge sets bit1 / R7 raw view");
        rd(A_CLR, "R8 masked view hides bit1 / R10 no summary");
        // R5 clear while line still high; R3 level does not re-set
        wr(A_CLR, 32'h0000_0002);
        rd(A_SET, "R3 held level after clear stays clear");
        // R4 write-one-to-set, R10 summary
        wr(A_SET, 32'h0000_0001);
        rd(A_CLR, "R4 set write / R8 masked view / R10 summary");
        step(4'b0000, 1'b0, A_SET, 32'h0, 1'b1, "R5 falling input does not clear");
        rd(A_SET, "R5 falling input does not clear (after)");
        // zeros written do nothing
        wr(A_SET, 32'h0);
        rd(A_SET, "R4 zero set write no effect");
        wr(A_CLR, 32'h0);
        rd(A_SET, "R5 zero clear write no effect");
        // R6 edge and clear on bit2 in one cycle
        step(4'b0100, 1'b1, A_CLR, 32'h0000_0004, 1'b0, "");
        rd(A_SET, "R6 edge beats clear");
        rd(A_CLR, "R6 masked view with bit2");
        // R11 unmapped address
        wr(8'hB0, 32'hFFFF_FFFF);
        rd(8'hB0, "R11 unmapped read zero");
        rd(A_SET, "R11 unmapped write leaves events");
        rd(A_MASK, "R11 unmapped write leaves mask");
        // R5 clear all, R10 summary drops
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_SET, "R5 clear all / R10 summary low");
        // All contexts edge together with full mask
        wr(A_MASK, 32'h0000_000F);
        step(4'b0000, 1'b0, A_SET, 32'h0, 1'b0, "");
        step(4'b1111, 1'b0, A_SET, 32'h0, 1'b0, "");
        rd(A_CLR, "R8 full mask view / R3 all edges");
        rd(8'h44, "R2 reserved and R11 read elsewhere");
        wr(A_MASK, 32'h0);
        rd(A_CLR, "R10 summary low with zero mask");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule